// File: doc/BRIEF.md
# General-Purpose I/O Port with Pad Readback Control

The block is a bank of general-purpose I/O pins controlled through a small word-addressed register bus. Software sets each pin's direction and output value. Each pin can drive its pad in push-pull fashion, or in open-drain fashion where it only ever pulls low. The pad levels come back through a two-stage synchronizer into a read-only status register.

A pin's input path is open when the pin is an input. It is also open when the pin's input-force bit is set, even if the pin is an output. While the input path is closed, the status bit reads 0. A read of the data register is resolved pin by pin:
- an output pin returns the bit software last wrote;
- an input pin returns its status bit.

Software can therefore detect an open-drain pin held low from outside only through the status register with input-force set. A data read on that pin still returns the written 1.

The register bus has no back-pressure. A read pulse always returns data with `bus_rvalid` in the following cycle. A write takes effect at the clock edge where it is sampled. The bus has these word addresses:

| Address | Register |
| --- | --- |
| 0x00 | Data |
| 0x01 | Direction |
| 0x02 | Status (read-only) |
| 0x20 + i | Configuration word of pin i |

Top module: `gpio_port`

## Requirements
- R1: For a pin whose direction bit is 0 (input), status bit i (address 0x02) equals the synchronized pad level.
- R2: For a pin whose direction bit is 1 (output) and whose input-force bit is 0, status bit i reads 0 whatever the pad level.
- R3: For an output pin, a read of data register bit i (address 0x00) returns the value software last wrote there, in both push-pull and open-drain mode.
- R4: For an input pin, a read of data register bit i returns the same value as status bit i.
- R5: Setting input-force opens pin i's input path regardless of direction, so status bit i follows the real pad level while the pin drives. Input-force is bit 30 of the configuration word at address 0x20+i.
- R6: In open-drain mode, an output pin written 1 whose pad is held low externally reads 1 through the data register. With input-force set, it reads 0 through the status register. Open-drain is selected by bit 0 of the configuration word.
- R7: After reset, every pin is an input, and the data bits, input-force bits and open-drain bits are all 0. In the direction register, 1 means output and 0 means input.
- R8: In push-pull mode, `pad_oe[i]` equals the direction bit and `pad_out[i]` equals the data bit. In open-drain mode, `pad_oe[i]` is high only when the pin is an output with data 0, and `pad_out[i]` is 0.
- R9: A pad change becomes visible in a status read after two clock edges of synchronizer latency. A read sampled at the second edge after the change still returns the old level; one sampled at the third edge returns the new level.
- R10: A write to the status address changes no register.
- R11: `bus_rvalid` is high in exactly the cycle after each cycle with `bus_rd` high. In that cycle `bus_rdata` holds the addressed word, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pad_in | input | NPIN | Pad levels seen at the pins |
| pad_out | output | NPIN | Value driven to each pad |
| pad_oe | output | NPIN | Output enable of each pad |

## Verification
The bench builds the block with its default eight pins and an 8-bit address, with the synchronizer at two stages. At that size, one byte pattern exercises mixed direction, input-force and open-drain settings across all pins at once, and the configuration words of both the first and the last pin can be reached. Back-to-back reads issued right after a pad change expose the exact synchronizer latency.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int DW       = 32;
  localparam int FORCE_IN = 30;
  localparam int OD_SEL   = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_STAT,
    SEL_CFG
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic dir,
  input  logic dat,
  input  logic od,
  input  logic force_in,
  input  logic lvl,
  output logic pad_out,
  output logic pad_oe,
  output logic stat,
  output logic rd_dat
);
  logic in_en;

  assign in_en   = ~dir | force_in;
  assign stat    = in_en & lvl;
  assign rd_dat  = dir ? dat : stat;
  assign pad_oe  = od ? (dir & ~dat) : dir;
  assign pad_out = od ? 1'b0 : dat;

  // R8: an open-drain pin written 1 releases its pad
  a_r8_od_release: assert property (@(posedge clk) disable iff (!rst_n)
    (od && dat) |-> !pad_oe);
  // R8: open-drain never drives a high level
  a_r8_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
    (od && pad_oe) |-> !pad_out);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPIN     = 8,
  parameter int AW       = 8,
  parameter int SYNC_STG = 2,
  parameter logic [AW-1:0] A_DATA   = 8'h00,
  parameter logic [AW-1:0] A_DIR    = 8'h01,
  parameter logic [AW-1:0] A_STAT   = 8'h02,
  parameter logic [AW-1:0] CFG_BASE = 8'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_rvalid,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  localparam int IW = (NPIN > 1) ? $clog2(NPIN) : 1;

  logic [NPIN-1:0] dat_q, dir_q, od_q, force_q;
  logic [NPIN-1:0] lvl, stat, rd_dat;
  logic [AW-1:0]   cfg_off;
  logic [IW-1:0]   cfg_idx;
  reg_sel_e        sel;
  logic [DW-1:0]   rd_word;

  assign cfg_off = bus_addr - CFG_BASE;
  assign cfg_idx = cfg_off[IW-1:0];

  always_comb begin
    if      (bus_addr == A_DATA) sel = SEL_DATA;
    else if (bus_addr == A_DIR)  sel = SEL_DIR;
    else if (bus_addr == A_STAT) sel = SEL_STAT;
    else if (bus_addr >= CFG_BASE && cfg_off < AW'(NPIN)) sel = SEL_CFG;
    else sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q   <= '0;
      dir_q   <= '0;
      od_q    <= '0;
      force_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DATA: dat_q <= bus_wdata[NPIN-1:0];
        SEL_DIR:  dir_q <= bus_wdata[NPIN-1:0];
        SEL_CFG: begin
          force_q[cfg_idx] <= bus_wdata[FORCE_IN];
          od_q[cfg_idx]    <= bus_wdata[OD_SEL];
        end
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl)
  );

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      gpio_pin u_pin (
        .clk(clk), .rst_n(rst_n),
        .dir(dir_q[i]), .dat(dat_q[i]), .od(od_q[i]), .force_in(force_q[i]),
        .lvl(lvl[i]), .pad_out(pad_out[i]), .pad_oe(pad_oe[i]),
        .stat(stat[i]), .rd_dat(rd_dat[i])
      );
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_DATA: rd_word[NPIN-1:0] = rd_dat;
      SEL_DIR:  rd_word[NPIN-1:0] = dir_q;
      SEL_STAT: rd_word[NPIN-1:0] = stat;
      SEL_CFG: begin
        rd_word[FORCE_IN] = force_q[cfg_idx];
        rd_word[OD_SEL]   = od_q[cfg_idx];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  // R11: every read answered in the next cycle, nothing else
  a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid == $past(bus_rd));
  // R2: output pins without input-force read 0 in status
  a_r2_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(bus_addr == A_STAT))
      |-> ((bus_rdata[NPIN-1:0] & $past(dir_q & ~force_q)) == '0));
  // R3: output pins read back the written data
  a_r3_dr_out: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(bus_addr == A_DATA))
      |-> (((bus_rdata[NPIN-1:0] ^ $past(dat_q)) & $past(dir_q)) == '0));
  // R10: status writes leave every register untouched
  a_r10_stat_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT)
      |=> ($stable(dat_q) && $stable(dir_q) && $stable(od_q) && $stable(force_q)));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  localparam int CLK_NS = 10;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [N-1:0] pad_in, pad_out, pad_oe;
  logic [N-1:0] ext = '0;

  // model state, from the requirements
  logic [N-1:0] m_dat = '0, m_dir = '0, m_od = '0, m_frc = '0;

  int vectors = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [N-1:0] f_oe();
    return (m_od & m_dir & ~m_dat) | (~m_od & m_dir);
  endfunction
  function automatic logic [N-1:0] f_out();
    return ~m_od & m_dat;
  endfunction
  function automatic logic [N-1:0] f_stat();
    logic [N-1:0] oe, pad;
    oe  = f_oe();
    pad = (oe & f_out()) | (~oe & ext);
    return (~m_dir | m_frc) & pad;
  endfunction
  function automatic logic [N-1:0] f_dr();
    return (m_dir & m_dat) | (~m_dir & f_stat());
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic issue(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bus_rd = 0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R11 unexpected rvalid actual=1 expected=0");
      end else begin
        chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    ext = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R7 reset state
    chk({24'd0, pad_oe}, 32'd0, "R7 reset oe");
    issue(8'h01, 32'd0, "R7 reset dir");
    issue(8'h20, 32'd0, "R7 reset cfg0");
    issue(8'h27, 32'd0, "R7 reset cfg7");
    issue(8'h02, 32'hA5, "R1 reset status");
    issue(8'h00, 32'hA5, "R4 reset data as input");
    issue(8'h55, 32'd0, "R11 unmapped");
    idle(2);

    // R1 input follows pad
    ext = 8'h3C; idle(4);
    issue(8'h02, {24'd0, f_stat()}, "R1 status 3C");
    idle(2);

    // R2/R3 all outputs, push-pull
    wr(8'h00, 32'h0F); m_dat = 8'h0F;
    wr(8'h01, 32'hFF); m_dir = 8'hFF;
    idle(4);
    chk({24'd0, pad_oe}, 32'hFF, "R8 pp oe");
    chk({24'd0, pad_out}, 32'h0F, "R8 pp out");
    issue(8'h02, 32'd0, "R2 outputs gated");
    issue(8'h00, 32'h0F, "R3 data readback");
    idle(2);

    // R4 mixed directions
    wr(8'h01, 32'hF0); m_dir = 8'hF0;
    ext = 8'h5A; idle(4);
    issue(8'h00, {24'd0, f_dr()}, "R4 mixed data");
    issue(8'h02, {24'd0, f_stat()}, "R1 mixed status");
    idle(2);

    // R5 input-force on pin 7 while driving
    wr(8'h00, 32'hF0); m_dat = 8'hF0;
    wr(8'h27, 32'h4000_0000); m_frc[7] = 1;
    idle(4);
    issue(8'h02, {24'd0, f_stat()}, "R5 force status");
    issue(8'h27, 32'h4000_0000, "R5 force cfg bit30");
    idle(2);

    // R6 open-drain pin 7, written 1, held low externally
    wr(8'h27, 32'h4000_0001); m_od[7] = 1;
    ext = 8'h5A & 8'h7F; idle(4);
    chk({31'd0, pad_oe[7]}, 32'd0, "R8 od released");
    chk({31'd0, pad_out[7]}, 32'd0, "R8 od out low");
    issue(8'h00, {24'd0, f_dr()}, "R6 od data reads written 1");
    issue(8'h02, {24'd0, f_stat()}, "R6 od status shows low");
    idle(2);
    ext[7] = 1; idle(4);
    issue(8'h02, {24'd0, f_stat()}, "R6 od status released high");
    idle(2);
    wr(8'h00, 32'h70); m_dat = 8'h70;
    idle(4);
    chk({31'd0, pad_oe[7]}, 32'd1, "R8 od drives low");
    issue(8'h02, {24'd0, f_stat()}, "R6 od status driven low");
    issue(8'h00, {24'd0, f_dr()}, "R3 od data 0");
    idle(2);

    // R10 status write ignored
    wr(8'h02, 32'hFFFF_FFFF);
    idle(4);
    issue(8'h00, {24'd0, f_dr()}, "R10 data after status write");
    issue(8'h01, {24'd0, m_dir}, "R10 dir after status write");
    issue(8'h27, 32'h4000_0001, "R10 cfg after status write");
    idle(2);

    // R9 synchronizer latency on input pins
    wr(8'h01, 32'h00); m_dir = 8'h00;
    ext = 8'h00; idle(4);
    @(negedge clk);
    ext = 8'hFF;
    issue(8'h02, 32'h00, "R9 edge1 old");
    issue(8'h02, 32'h00, "R9 edge2 old");
    issue(8'h02, 32'hFF, "R9 edge3 new");
    idle(3);

    if (exp_q.size() != 0) chk(exp_q.size(), 0, "R11 missing responses");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule